// File: doc/BRIEF.md
# Interval Tick Timer

The block raises a periodic interrupt at a rate that software selects through a 9-bit reload value. A one-cycle clock-enable pulse arrives once per millisecond on `base_tick`. The block counts these pulses and raises `irq` when reload+1 of them have passed since the period started. The next period then begins on its own, so the interrupt rate is 1000/(reload+1) Hz.

Software reaches the block through a small register port. A write to the reload offset stores the new value, clears the interrupt and starts a new period at once. A read of the count offset returns zero and acknowledges the interrupt. An interrupt that software has not acknowledged stays high through any later expiries. Read data is registered and appears one cycle after the read request.

Top module: `tick_timer`

## Requirements
- R1: A write to offset 0x4 keeps only wdata[8:0] as the reload value. A read of offset 0x4 returns that value zero-extended.
- R2: After a reload write, the period expires on exactly the (reload+1)-th `base_tick` pulse. Clock cycles without `base_tick` do not advance the period.
- R3: A write to offset 0x4 drives `irq` low from the next clock edge and restarts the period counting from zero.
- R4: When a period expires, `irq` goes high one edge later and the next period of reload+1 pulses starts with no software action.
- R5: A read of offset 0x0 returns 0 and drives `irq` low from the next edge.
- R6: After reset, the reload value is 0, `irq` is low and `rdata` is 0.
- R7: If `irq` is already high and no acknowledge or reload write arrives, `irq` stays high through further expiries.
- R8: If a reload write and a `base_tick` pulse arrive in the same cycle, the write wins. `irq` goes low and the new period counts from that cycle.
- R9: If a read of offset 0x0 and an expiry happen in the same cycle, `irq` is high afterwards.
- R10: Writes to offset 0x0 or to any unmapped offset do not change the reload value. Reads of unmapped offsets return 0.
- R11: `rdata` shows the read result one cycle after `rd_en`, and is 0 in any cycle that follows no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_tick | input | 1 | One-cycle pulse per millisecond |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Register offset (0x0 count, 0x4 reload) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq | output | 1 | Periodic interrupt, level |

## Verification
Every result of the block shows up one clock edge after the cycle that causes it. This holds for `irq` after an expiry, a reload write or an acknowledge, and for `rdata` after a read request. The bench drives each stimulus for one full cycle starting at a falling edge and samples outputs at the next falling edge, half a cycle after the edge that registered them. The same-cycle collisions in R8 and R9 are driven in one cycle, so the priority between events is checked at that single edge.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
   // Events decoded from the register port, delivered to the timer core.
   typedef struct packed {
      logic reload_wr;   // write to the reload offset
      logic count_rd;    // read of the count offset (acknowledge)
   } tt_event_t;

   // Zero-extend a reload value onto the data bus.
   function automatic logic [63:0] tt_zext(input logic [63:0] v, input int unsigned w);
      logic [63:0] m;
      m = (w >= 64) ? {64{1'b1}} : ((64'd1 << w) - 64'd1);
      return v & m;
   endfunction
endpackage

// File: rtl/tick_timer_regs.sv
module tick_timer_regs
   import tick_timer_pkg::*;
#(
   parameter int unsigned ADDR_W      = 4,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned RELOAD_W    = 9,
   parameter logic [ADDR_W-1:0] COUNT_OFS  = 'h0,
   parameter logic [ADDR_W-1:0] RELOAD_OFS = 'h4,
   parameter bit          READ_REG    = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic                rd_en,
   input  logic [ADDR_W-1:0]   addr,
   input  logic [DATA_W-1:0]   wdata,
   output logic [RELOAD_W-1:0] reload_q,
   output logic [RELOAD_W-1:0] reload_nxt,
   output tt_event_t           ev,
   output logic [DATA_W-1:0]   rdata
);
   localparam int unsigned PAD_W = DATA_W - RELOAD_W;

   logic [DATA_W-1:0] rd_val;

   always_comb begin
      ev.reload_wr = wr_en && (addr == RELOAD_OFS);
      ev.count_rd  = rd_en && (addr == COUNT_OFS);
      reload_nxt   = wdata[RELOAD_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) reload_q <= '0;
      else if (ev.reload_wr) reload_q <= reload_nxt;
   end

   // Readback mux: count offset always reads zero, unmapped reads zero.
   always_comb begin
      rd_val = '0;
      if (rd_en && (addr == RELOAD_OFS)) rd_val = {{PAD_W{1'b0}}, reload_q};
   end

   generate
      if (READ_REG) begin : g_rd_reg
         always_ff @(posedge clk) begin
            if (!rst_n) rdata <= '0;
            else        rdata <= rd_val;
         end
      end else begin : g_rd_comb
         assign rdata = rd_val;
      end
   endgenerate

   // R1: only the low bits of the write data are retained
   a_r1_reload_masked: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == RELOAD_OFS) |=> (reload_q == $past(wdata[RELOAD_W-1:0])));

   // R10: no write to another offset changes the reload value
   a_r10_other_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && addr == RELOAD_OFS) |=> $stable(reload_q));
endmodule

// File: rtl/tick_timer_period.sv
module tick_timer_period #(
   parameter int unsigned RELOAD_W = 9
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                base_tick,
   input  logic                reload_wr,
   input  logic [RELOAD_W-1:0] reload_nxt,
   input  logic [RELOAD_W-1:0] reload_q,
   output logic                expire
);
   logic [RELOAD_W-1:0] remain_q;

   // A reload write overrides a coincident tick: no expiry that cycle.
   assign expire = base_tick && (remain_q == '0) && !reload_wr;

   always_ff @(posedge clk) begin
      if (!rst_n)                remain_q <= '0;
      else if (reload_wr)        remain_q <= reload_nxt;
      else if (base_tick) begin
         if (remain_q == '0)     remain_q <= reload_q;
         else                    remain_q <= remain_q - 1'b1;
      end
   end

   // R2: the remaining count never exceeds the programmed reload
   a_r2_remain_bound: assert property (@(posedge clk) disable iff (!rst_n)
      remain_q <= reload_q);

   // R4: an expiry restarts a full period automatically
   a_r4_auto_restart: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> (remain_q == $past(reload_q)));

   // R2: without a tick or write the counter holds
   a_r2_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (!base_tick && !reload_wr) |=> $stable(remain_q));
endmodule

// File: rtl/tick_timer_irq.sv
module tick_timer_irq (
   input  logic clk,
   input  logic rst_n,
   input  logic expire,
   input  logic reload_wr,
   input  logic count_rd,
   output logic irq
);
   // Priority: reload write clears, then expiry sets, then acknowledge clears.
   always_ff @(posedge clk) begin
      if (!rst_n)         irq <= 1'b0;
      else if (reload_wr) irq <= 1'b0;
      else if (expire)    irq <= 1'b1;
      else if (count_rd)  irq <= 1'b0;
   end

   // R3: a reload write lowers the interrupt
   a_r3_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
      reload_wr |=> !irq);

   // R4 and R9: an expiry raises the interrupt even with a coincident acknowledge
   a_r4_expire_sets: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> irq);

   // R5: acknowledge without expiry lowers the interrupt
   a_r5_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (count_rd && !expire) |=> !irq);

   // R7: a pending interrupt stays until acknowledged or rewritten
   a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !count_rd && !reload_wr) |=> irq);
endmodule

// File: rtl/tick_timer.sv
module tick_timer
   import tick_timer_pkg::*;
#(
   parameter int unsigned ADDR_W     = 4,
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned RELOAD_W   = 9,
   parameter logic [ADDR_W-1:0] COUNT_OFS  = 'h0,
   parameter logic [ADDR_W-1:0] RELOAD_OFS = 'h4,
   parameter bit          READ_REG   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              base_tick,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              irq
);
   generate
      if (RELOAD_W < 1 || RELOAD_W > DATA_W) begin : g_bad_width
         $error("tick_timer: RELOAD_W must be in 1..DATA_W");
      end
      if (COUNT_OFS == RELOAD_OFS) begin : g_bad_ofs
         $error("tick_timer: register offsets must differ");
      end
   endgenerate

   logic [RELOAD_W-1:0] reload_q;
   logic [RELOAD_W-1:0] reload_nxt;
   tt_event_t           ev;
   logic                expire;

   tick_timer_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RELOAD_W(RELOAD_W),
      .COUNT_OFS(COUNT_OFS), .RELOAD_OFS(RELOAD_OFS), .READ_REG(READ_REG)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .reload_q(reload_q), .reload_nxt(reload_nxt), .ev(ev),
      .rdata(rdata)
   );

   tick_timer_period #(.RELOAD_W(RELOAD_W)) u_period (
      .clk(clk), .rst_n(rst_n), .base_tick(base_tick), .reload_wr(ev.reload_wr),
      .reload_nxt(reload_nxt), .reload_q(reload_q), .expire(expire)
   );

   tick_timer_irq u_irq (
      .clk(clk), .rst_n(rst_n), .expire(expire), .reload_wr(ev.reload_wr),
      .count_rd(ev.count_rd), .irq(irq)
   );

   // R5: the count offset always reads back zero
   a_r5_count_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && addr == COUNT_OFS) |=> (READ_REG ? (rdata == '0) : 1'b1));

   // R11: no read request leaves rdata at zero
   a_r11_idle_rdata: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_en && READ_REG) |=> (rdata == '0));
endmodule

// File: tb/tick_timer_tb.sv
module tick_timer_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        base_tick = 1'b0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [3:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   tick_timer u_dut (
      .clk(clk), .rst_n(rst_n), .base_tick(base_tick), .wr_en(wr_en),
      .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
   );

   // {write value[15:0], ticks[7:0], expected irq}
   localparam logic [24:0] VEC [8] = '{
      {16'h0000, 8'd1,  1'b1},
      {16'h0003, 8'd3,  1'b0},
      {16'h0003, 8'd4,  1'b1},
      {16'h0205, 8'd5,  1'b0},
      {16'h0205, 8'd6,  1'b1},
      {16'h0007, 8'd0,  1'b0},
      {16'hFE01, 8'd2,  1'b1},
      {16'h000A, 8'd10, 1'b0}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // One cycle of bus and tick activity, then sample at the next falling edge.
   task automatic cyc(input logic w, input logic r, input logic [3:0] a,
                      input logic [31:0] d, input logic t);
      @(negedge clk);
      wr_en = w; rd_en = r; addr = a; wdata = d; base_tick = t;
      @(negedge clk);
      wr_en = 0; rd_en = 0; base_tick = 0;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         cyc(0, 0, 4'h0, 32'h0, 1);
         cyc(0, 0, 4'h0, 32'h0, 0);
      end
   endtask

   initial begin
      #(5ns * 100000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R6 reset state
      check("R6 irq", {31'b0, irq}, 32'h0);
      check("R6 rdata", rdata, 32'h0);
      cyc(0, 1, 4'h4, 32'h0, 0);
      check("R6 reload", rdata, 32'h0);

      // Vector table: R1, R2, R3, R5
      for (int v = 0; v < 8; v++) begin
         logic [15:0] wv;
         logic [7:0]  nt;
         logic        ei;
         {wv, nt, ei} = VEC[v];
         cyc(1, 0, 4'h4, {16'h0, wv}, 0);
         check("R3 irq after write", {31'b0, irq}, 32'h0);
         ticks(nt);
         check("R2 irq after ticks", {31'b0, irq}, {31'b0, (32'(nt) >= 32'(wv & 16'h01FF) + 1)});
         check("R2 table expectation", {31'b0, irq}, {31'b0, ei});
         cyc(0, 1, 4'h4, 32'h0, 0);
         check("R1 reload readback", rdata, {23'b0, wv[8:0]});
         cyc(0, 1, 4'h0, 32'h0, 0);
         check("R5 count reads 0", rdata, 32'h0);
         check("R5 ack clears", {31'b0, irq}, 32'h0);
         cyc(0, 0, 4'h0, 32'h0, 0);
         check("R11 idle rdata", rdata, 32'h0);
      end

      // R4 automatic restart
      cyc(1, 0, 4'h4, 32'h2, 0);
      ticks(3);
      check("R4 first expiry", {31'b0, irq}, 32'h1);
      cyc(0, 1, 4'h0, 32'h0, 0);
      check("R5 ack", {31'b0, irq}, 32'h0);
      ticks(2);
      check("R4 not yet", {31'b0, irq}, 32'h0);
      ticks(1);
      check("R4 second expiry", {31'b0, irq}, 32'h1);
      // R7 sticky across expiries
      ticks(4);
      check("R7 stays high", {31'b0, irq}, 32'h1);

      // R2 no ticks: no progress
      cyc(1, 0, 4'h4, 32'h0, 0);
      repeat (20) @(negedge clk);
      check("R2 no tick no expiry", {31'b0, irq}, 32'h0);

      // R8 write and tick together: write wins
      ticks(1);
      check("R8 setup irq", {31'b0, irq}, 32'h1);
      cyc(1, 0, 4'h4, 32'h1, 1);
      check("R8 write wins", {31'b0, irq}, 32'h0);
      ticks(1);
      check("R8 fresh period 1", {31'b0, irq}, 32'h0);
      ticks(1);
      check("R8 fresh period 2", {31'b0, irq}, 32'h1);

      // R9 read and expiry together
      cyc(1, 0, 4'h4, 32'h0, 0);
      cyc(0, 1, 4'h0, 32'h0, 1);
      check("R9 expiry beats ack", {31'b0, irq}, 32'h1);
      check("R9 rdata zero", rdata, 32'h0);

      // R10 other offsets ignored
      cyc(1, 0, 4'h4, 32'h5, 0);
      cyc(1, 0, 4'h8, 32'h1FF, 0);
      cyc(1, 0, 4'h0, 32'h1FF, 0);
      cyc(0, 1, 4'h4, 32'h0, 0);
      check("R10 reload unchanged", rdata, 32'h5);
      cyc(0, 1, 4'h8, 32'h0, 0);
      check("R10 unmapped read", rdata, 32'h0);

      // R1 full-width write
      cyc(1, 0, 4'h4, 32'hFFFF_FFFF, 0);
      cyc(0, 1, 4'h4, 32'h0, 0);
      check("R1 mask", rdata, 32'h1FF);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule